// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block tracks the producer and consumer positions of a ring buffer kept in system memory, such as a command or event ring serviced by an address-translation unit. The ring holds a power-of-two number of entries chosen at run time by a log2 size value. Each pointer carries the entry index in its low bits and a wrap flag directly above them, so a full ring and an empty ring can be told apart without a separate count.

The block answers full and empty, steps either pointer on request, and forms the memory byte address of the entry under each pointer. It does this from an aligned base register and an entry size in bytes. The consumer register also carries a 7-bit error code. Pointer steps and pointer loads leave that code untouched, and it changes only through its own write strobe. Software may load either pointer directly and read both back as 32-bit register images.

Top module: `ringq_ptr_mgr`

## Requirements
- R1: After reset both pointers, the error code, the log2 size and both sticky flags are zero. `q_empty` is 1 and `q_full` is 0.
- R2: The log2 size is taken from `cfg_log2` on each clock edge where `q_en` is 0 and `cfg_log2` is at most 19. While `q_en` is 1, or when the value exceeds 19, the previous size is kept.
- R3: With L the log2 size, `q_empty` is 1 exactly when bits L:0 of the two pointers are equal.
- R4: `q_full` is 1 exactly when bits L:0 of the two pointers, XORed together, equal 2^L. This means the indices match and the wrap flags differ.
- R5: A producer step sets the producer pointer to (pointer + 1) masked to bits L:0, which clears every bit above L. A step requested while full is dropped and sets `ovf_flag`, which stays set until reset.
- R6: A consumer step replaces only bits L:0 of the consumer pointer with the incremented value, and leaves its higher pointer bits and the error code unchanged. A step requested while empty is dropped and sets `udf_flag`, which stays set until reset.
- R7: `prod_we` or `cons_we` loads all 20 pointer bits from the write data. A load takes priority over a step on the same edge. A consumer load leaves the error code unchanged.
- R8: `err_we` loads `err_code` into bits 30:24 of the consumer register and nothing else. `cons_rdata` holds the pointer in bits 19:0, the error code in bits 30:24 and zeros elsewhere. `prod_rdata` holds the pointer in bits 19:0 and zeros elsewhere.
- R9: Each entry address equals the base register with its low 5 bits cleared, plus `entry_bytes` times the pointer's low L bits, taken modulo 2^48. The base register is loaded by `base_we`. Full, empty and both addresses follow the stored state in the same cycle, with no added register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| q_en | input | 1 | Ring enabled; freezes the log2 size while high |
| cfg_log2 | input | 5 | Requested log2 of the ring depth (0..19) |
| base_we | input | 1 | Load strobe for the base register |
| base_wdata | input | 48 | New base address |
| entry_bytes | input | 8 | Entry size in bytes |
| prod_inc | input | 1 | Step the producer pointer |
| cons_inc | input | 1 | Step the consumer pointer |
| prod_we | input | 1 | Load the producer pointer |
| prod_wdata | input | 20 | Producer pointer load value |
| cons_we | input | 1 | Load the consumer pointer |
| cons_wdata | input | 20 | Consumer pointer load value |
| err_we | input | 1 | Load the error code |
| err_code | input | 7 | Error code value |
| q_full | output | 1 | Ring full |
| q_empty | output | 1 | Ring empty |
| prod_rdata | output | 32 | Producer register image |
| cons_rdata | output | 32 | Consumer register image with error code |
| prod_addr | output | 48 | Byte address of the producer entry |
| cons_addr | output | 48 | Byte address of the consumer entry |
| ovf_flag | output | 1 | Sticky: producer step refused while full |
| udf_flag | output | 1 | Sticky: consumer step refused while empty |

## Verification
Every output is a combinational function of the stored pointers, size, base and error code. A corrupted pointer, a misplaced wrap bit or a lost error code therefore shows on `prod_rdata`, `cons_rdata`, the addresses and the full/empty pair in the cycle right after the bad edge. The sweeps compare all eight outputs after every single edge at sizes 0 to 4, so a wrong wrap-bit position shows within one lap of the ring. A dropped or wrongly accepted step shows at once as a pointer mismatch and as a missing or spurious sticky flag.

// File: rtl/ringq_pkg.sv
package ringq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ERR_W   = 7;
  localparam int unsigned ERR_LSB = 24;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_LOAD = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/ringq_size_cfg.sv
module ringq_size_cfg #(
  parameter int unsigned MAX_LOG2 = 19,
  parameter int unsigned LOG2_W   = 5,
  parameter int unsigned PTR_W    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_en,
  input  logic [LOG2_W-1:0] cfg_log2,
  output logic [PTR_W-1:0]  wrap_bit,
  output logic [PTR_W-1:0]  wrap_mask,
  output logic [PTR_W-1:0]  idx_mask
);
  logic [LOG2_W-1:0] log2_q;
  logic [LOG2_W-1:0] log2_d;
  logic              cfg_ok;
  logic              log2_en;

  always_comb begin
    cfg_ok  = (cfg_log2 <= LOG2_W'(MAX_LOG2));
    log2_en = !q_en && cfg_ok;
    log2_d  = cfg_log2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log2_q <= '0;
    end else if (log2_en) begin
      log2_q <= log2_d;
    end
  end

  always_comb begin
    wrap_bit  = PTR_W'(1) << log2_q;
    wrap_mask = (wrap_bit << 1) - PTR_W'(1);
    idx_mask  = wrap_bit - PTR_W'(1);
  end

  // R2: size frozen while the ring is enabled
  a_r2_size_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    q_en |=> $stable(log2_q));
  // R2: stored size never leaves the legal range
  a_r2_size_range: assert property (@(posedge clk) disable iff (!rst_n)
    log2_q <= LOG2_W'(MAX_LOG2));
  // R4: exactly one wrap position is marked
  a_r4_wrap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wrap_bit) == 1);
endmodule

// File: rtl/ringq_ptr_unit.sv
module ringq_ptr_unit
  import ringq_pkg::*;
#(
  parameter int unsigned PTR_W   = 20,
  parameter bit          DEPOSIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             blocked,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  input  logic [PTR_W-1:0] wrap_mask,
  output logic [PTR_W-1:0] ptr_q,
  output logic             refused_q
);
  ptr_op_e          op;
  logic [PTR_W-1:0] step_val;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             refuse_set;
  logic [PTR_W-1:0] bumped;

  assign bumped = ptr_q + PTR_W'(1);

  generate
    if (DEPOSIT) begin : g_deposit
      assign step_val = (ptr_q & ~wrap_mask) | (bumped & wrap_mask);
    end else begin : g_masked
      assign step_val = bumped & wrap_mask;
    end
  endgenerate

  always_comb begin
    if (we) begin
      op = PTR_LOAD;
    end else if (inc && !blocked) begin
      op = PTR_STEP;
    end else begin
      op = PTR_HOLD;
    end
    unique case (op)
      PTR_LOAD: ptr_d = wdata;
      PTR_STEP: ptr_d = step_val;
      default:  ptr_d = ptr_q;
    endcase
    ptr_en     = (op != PTR_HOLD);
    refuse_set = inc && blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refused_q <= 1'b0;
    end else if (refuse_set) begin
      refused_q <= 1'b1;
    end
  end

  // R5 R6: a refused step leaves the pointer alone
  a_r5_r6_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    inc && blocked && !we |=> $stable(ptr_q));
  // R5 R6: refusal flags are sticky
  a_r5_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    refused_q |=> refused_q);
  // R7: a load takes the written value
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr_q == $past(wdata));

  generate
    if (DEPOSIT) begin : g_chk_dep
      // R6: bits above the wrap flag survive a step
      a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !blocked && !we |=>
          (ptr_q & ~$past(wrap_mask)) == ($past(ptr_q) & ~$past(wrap_mask)));
    end else begin : g_chk_msk
      // R5: bits above the wrap flag are cleared by a step
      a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !blocked && !we |=> (ptr_q & ~$past(wrap_mask)) == '0);
    end
  endgenerate
endmodule

// File: rtl/ringq_occupancy.sv
module ringq_occupancy #(
  parameter int unsigned PTR_W = 20
) (
  input  logic [PTR_W-1:0] prod_ptr,
  input  logic [PTR_W-1:0] cons_ptr,
  input  logic [PTR_W-1:0] wrap_bit,
  input  logic [PTR_W-1:0] wrap_mask,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] diff;

  always_comb begin
    diff  = (prod_ptr ^ cons_ptr) & wrap_mask;
    full  = (diff == wrap_bit);
    empty = (diff == '0);
  end
endmodule

// File: rtl/ringq_addr_gen.sv
module ringq_addr_gen #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned ESZ_W      = 8,
  parameter int unsigned PTR_W      = 20,
  parameter int unsigned ALIGN_BITS = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ESZ_W-1:0]  entry_bytes,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  idx_mask,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  logic [PTR_W-1:0]  idx;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    idx    = ptr & idx_mask;
    offset = ADDR_W'(entry_bytes) * ADDR_W'(idx);
    addr   = (base & BASE_MASK) + offset;
  end
endmodule

// File: rtl/ringq_ptr_mgr.sv
module ringq_ptr_mgr
  import ringq_pkg::*;
#(
  parameter int unsigned MAX_LOG2   = 19,
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned ESZ_W      = 8,
  parameter int unsigned ALIGN_BITS = 5,
  localparam int unsigned LOG2_W    = $clog2(MAX_LOG2 + 1),
  localparam int unsigned PTR_W     = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_en,
  input  logic [LOG2_W-1:0] cfg_log2,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic [ESZ_W-1:0]  entry_bytes,
  input  logic              prod_inc,
  input  logic              cons_inc,
  input  logic              prod_we,
  input  logic [PTR_W-1:0]  prod_wdata,
  input  logic              cons_we,
  input  logic [PTR_W-1:0]  cons_wdata,
  input  logic              err_we,
  input  logic [ERR_W-1:0]  err_code,
  output logic              q_full,
  output logic              q_empty,
  output logic [REG_W-1:0]  prod_rdata,
  output logic [REG_W-1:0]  cons_rdata,
  output logic [ADDR_W-1:0] prod_addr,
  output logic [ADDR_W-1:0] cons_addr,
  output logic              ovf_flag,
  output logic              udf_flag
);
  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [PTR_W-1:0]  wrap_bit;
  logic [PTR_W-1:0]  wrap_mask;
  logic [PTR_W-1:0]  idx_mask;
  logic [PTR_W-1:0]  prod_ptr;
  logic [PTR_W-1:0]  cons_ptr;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [ERR_W-1:0]  err_q;
  logic [ERR_W-1:0]  err_d;

  ringq_size_cfg #(
    .MAX_LOG2 (MAX_LOG2),
    .LOG2_W   (LOG2_W),
    .PTR_W    (PTR_W)
  ) u_size (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .q_en      (q_en),
    .cfg_log2  (cfg_log2),
    .wrap_bit  (wrap_bit),
    .wrap_mask (wrap_mask),
    .idx_mask  (idx_mask)
  );

  ringq_occupancy #(.PTR_W(PTR_W)) u_occ (
    .prod_ptr  (prod_ptr),
    .cons_ptr  (cons_ptr),
    .wrap_bit  (wrap_bit),
    .wrap_mask (wrap_mask),
    .full      (q_full),
    .empty     (q_empty)
  );

  ringq_ptr_unit #(.PTR_W(PTR_W), .DEPOSIT(1'b0)) u_prod (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inc       (prod_inc),
    .blocked   (q_full),
    .we        (prod_we),
    .wdata     (prod_wdata),
    .wrap_mask (wrap_mask),
    .ptr_q     (prod_ptr),
    .refused_q (ovf_flag)
  );

  ringq_ptr_unit #(.PTR_W(PTR_W), .DEPOSIT(1'b1)) u_cons (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inc       (cons_inc),
    .blocked   (q_empty),
    .we        (cons_we),
    .wdata     (cons_wdata),
    .wrap_mask (wrap_mask),
    .ptr_q     (cons_ptr),
    .refused_q (udf_flag)
  );

  ringq_addr_gen #(
    .ADDR_W     (ADDR_W),
    .ESZ_W      (ESZ_W),
    .PTR_W      (PTR_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_prod_addr (
    .base        (base_q),
    .entry_bytes (entry_bytes),
    .ptr         (prod_ptr),
    .idx_mask    (idx_mask),
    .addr        (prod_addr)
  );

  ringq_addr_gen #(
    .ADDR_W     (ADDR_W),
    .ESZ_W      (ESZ_W),
    .PTR_W      (PTR_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_cons_addr (
    .base        (base_q),
    .entry_bytes (entry_bytes),
    .ptr         (cons_ptr),
    .idx_mask    (idx_mask),
    .addr        (cons_addr)
  );

  always_comb begin
    base_d = base_wdata;
    err_d  = err_code;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= '0;
    end else if (err_we) begin
      err_q <= err_d;
    end
  end

  always_comb begin
    prod_rdata                     = '0;
    prod_rdata[PTR_W-1:0]          = prod_ptr;
    cons_rdata                     = '0;
    cons_rdata[PTR_W-1:0]          = cons_ptr;
    cons_rdata[ERR_LSB +: ERR_W]   = err_q;
  end

  // R3 R4: full and empty never coincide
  a_r3_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(q_full && q_empty));
  // R8: error code holds unless written
  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !err_we |=> $stable(err_q));
  // R8: error write lands in the register image
  a_r8_err_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_we |=> cons_rdata[ERR_LSB +: ERR_W] == $past(err_code));
  // R9: base register holds unless written
  a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !base_we |=> $stable(base_q));
endmodule

// File: tb/ringq_ptr_mgr_tb.sv
module ringq_ptr_mgr_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        q_en;
  logic [4:0]  cfg_log2;
  logic        base_we;
  logic [47:0] base_wdata;
  logic [7:0]  entry_bytes;
  logic        prod_inc;
  logic        cons_inc;
  logic        prod_we;
  logic [19:0] prod_wdata;
  logic        cons_we;
  logic [19:0] cons_wdata;
  logic        err_we;
  logic [6:0]  err_code;
  logic        q_full;
  logic        q_empty;
  logic [31:0] prod_rdata;
  logic [31:0] cons_rdata;
  logic [47:0] prod_addr;
  logic [47:0] cons_addr;
  logic        ovf_flag;
  logic        udf_flag;

  ringq_ptr_mgr u_dut (
    .clk (clk), .rst_n (rst_n), .q_en (q_en), .cfg_log2 (cfg_log2),
    .base_we (base_we), .base_wdata (base_wdata), .entry_bytes (entry_bytes),
    .prod_inc (prod_inc), .cons_inc (cons_inc),
    .prod_we (prod_we), .prod_wdata (prod_wdata),
    .cons_we (cons_we), .cons_wdata (cons_wdata),
    .err_we (err_we), .err_code (err_code),
    .q_full (q_full), .q_empty (q_empty),
    .prod_rdata (prod_rdata), .cons_rdata (cons_rdata),
    .prod_addr (prod_addr), .cons_addr (cons_addr),
    .ovf_flag (ovf_flag), .udf_flag (udf_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // bench model of the architectural state
  logic [19:0] m_p, m_c;
  logic [6:0]  m_err;
  logic [47:0] m_base;
  int          m_L;
  bit          m_ovf, m_udf;

  function automatic logic [19:0] wmask(int L);
    return 20'((32'd1 << (L + 1)) - 1);
  endfunction

  function automatic bit mdl_full();
    return ((m_p ^ m_c) & wmask(m_L)) == 20'(32'd1 << m_L);
  endfunction

  function automatic bit mdl_empty();
    return ((m_p ^ m_c) & wmask(m_L)) == 20'd0;
  endfunction

  function automatic logic [47:0] mdl_addr(logic [19:0] ptr);
    logic [47:0] idx;
    idx = 48'(ptr) & 48'((32'd1 << m_L) - 1);
    return (m_base & 48'hFFFF_FFFF_FFE0) + 48'(entry_bytes) * idx;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " full"},       64'(q_full),     64'(mdl_full()));
    chk({tag, " empty"},      64'(q_empty),    64'(mdl_empty()));
    chk({tag, " prod_rdata"}, 64'(prod_rdata), 64'({12'd0, m_p}));
    chk({tag, " cons_rdata"}, 64'(cons_rdata), 64'({1'b0, m_err, 4'd0, m_c}));
    chk({tag, " R9 prod_addr"}, 64'(prod_addr), 64'(mdl_addr(m_p)));
    chk({tag, " R9 cons_addr"}, 64'(cons_addr), 64'(mdl_addr(m_c)));
    chk({tag, " R5 ovf"},     64'(ovf_flag),   64'(m_ovf));
    chk({tag, " R6 udf"},     64'(udf_flag),   64'(m_udf));
  endtask

  task automatic clock_edge();
    @(posedge clk);
    #1;
  endtask

  // one cycle of optional steps
  task automatic cyc(bit push, bit pop, string tag);
    bit f, e;
    f = mdl_full();
    e = mdl_empty();
    prod_inc = push;
    cons_inc = pop;
    clock_edge();
    prod_inc = 1'b0;
    cons_inc = 1'b0;
    if (push) begin
      if (f) m_ovf = 1'b1;
      else   m_p = (m_p + 20'd1) & wmask(m_L);
    end
    if (pop) begin
      if (e) m_udf = 1'b1;
      else   m_c = (m_c & ~wmask(m_L)) | ((m_c + 20'd1) & wmask(m_L));
    end
    check_all(tag);
  endtask

  task automatic set_log2(int v, string tag);
    q_en     = 1'b0;
    cfg_log2 = 5'(v);
    clock_edge();
    q_en = 1'b1;
    if (v <= 19) m_L = v;
    check_all(tag);
  endtask

  task automatic wr_base(logic [47:0] v);
    base_we    = 1'b1;
    base_wdata = v;
    clock_edge();
    base_we = 1'b0;
    m_base  = v;
    check_all("R9 base");
  endtask

  // pointer load, with an optional competing step on the same edge
  task automatic wr_prod(logic [19:0] v, bit push);
    bit f;
    f = mdl_full();
    prod_we    = 1'b1;
    prod_wdata = v;
    prod_inc   = push;
    clock_edge();
    prod_we  = 1'b0;
    prod_inc = 1'b0;
    if (push && f) m_ovf = 1'b1;
    m_p = v;
    check_all("R7 prod load");
  endtask

  task automatic wr_cons(logic [19:0] v, bit pop);
    bit e;
    e = mdl_empty();
    cons_we    = 1'b1;
    cons_wdata = v;
    cons_inc   = pop;
    clock_edge();
    cons_we  = 1'b0;
    cons_inc = 1'b0;
    if (pop && e) m_udf = 1'b1;
    m_c = v;
    check_all("R7 cons load");
  endtask

  task automatic wr_err(logic [6:0] v);
    err_we   = 1'b1;
    err_code = v;
    clock_edge();
    err_we = 1'b0;
    m_err  = v;
    check_all("R8 err");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; q_en = 1'b0; cfg_log2 = '0;
    base_we = 1'b0; base_wdata = '0; entry_bytes = 8'd16;
    prod_inc = 1'b0; cons_inc = 1'b0;
    prod_we = 1'b0; prod_wdata = '0; cons_we = 1'b0; cons_wdata = '0;
    err_we = 1'b0; err_code = '0;
    m_p = '0; m_c = '0; m_err = '0; m_base = '0; m_L = 0;
    m_ovf = 1'b0; m_udf = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 empty", 64'(q_empty), 64'd1);
    chk("R1 full",  64'(q_full),  64'd0);
    check_all("R1");

    // R2: size held while enabled, and out-of-range values ignored
    set_log2(2, "R2");
    cfg_log2 = 5'd3;
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R2 enabled");
    chk("R2 full at 4", 64'(q_full), 64'd1);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R2 drain");
    set_log2(25, "R2 too big");
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "R2 kept");
    chk("R2 full kept", 64'(q_full), 64'd1);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R2 drain2");

    wr_base(48'h1234_5678_9ABF);

    // sweep sizes 0..4: fill past full, drain past empty, mixed pattern
    for (int L = 0; L <= 4; L++) begin
      int n;
      entry_bytes = 8'(8 << (L % 3));
      set_log2(L, "R2 sweep");
      n = 1 << L;
      for (int s = 0; s <= n; s++) cyc(1'b1, 1'b0, "R4 R5 fill");
      for (int s = 0; s <= n; s++) cyc(1'b0, 1'b1, "R3 R6 drain");
      for (int s = 0; s < 4 * n + 4; s++) begin
        int k;
        k = (s * 5 + 1) % 4;
        cyc(k == 1 || k == 3, k >= 2, "R3 R4 mixed");
      end
      if (L == 2) wr_base(48'hFEDC_BA98_7654);
    end

    // R8: error field survives steps and loads
    wr_err(7'h55);
    cyc(1'b1, 1'b0, "R8 push");
    cyc(1'b0, 1'b1, "R8 pop");
    wr_cons(20'h00003, 1'b0);
    chk("R8 err after load", 64'(cons_rdata[30:24]), 64'h55);

    // R7 and R6: loads beat steps; consumer keeps upper pointer bits
    set_log2(2, "R2 L2");
    wr_prod(20'hFFFFF, 1'b1);
    wr_cons(20'hFFFFB, 1'b1);
    cyc(1'b0, 1'b1, "R6 upper kept");
    cyc(1'b1, 1'b0, "R5 upper cleared");
    wr_err(7'h2A);
    cyc(1'b0, 1'b1, "R6 err kept");

    // R4 R3 at the largest size
    set_log2(19, "R2 max");
    wr_prod(20'hFFFFF, 1'b0);
    wr_cons(20'h7FFFF, 1'b0);
    chk("R4 full at max", 64'(q_full), 64'd1);
    cyc(1'b1, 1'b0, "R5 refuse max");
    wr_cons(20'hFFFFF, 1'b0);
    chk("R3 empty at max", 64'(q_empty), 64'd1);
    cyc(1'b0, 1'b1, "R6 refuse max");
    cyc(1'b1, 1'b0, "R5 wrap max");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule